// File: doc/BRIEF.md
# DRAM Geometry Probe

This block works out how many multiplexed row/column address bits an attached DRAM supports. It runs by itself as soon as reset is released, and it runs again whenever a start pulse arrives after the previous run has finished. It does not drive RAS, CAS or WE itself. Instead it hands single-byte write and read requests to an external access controller, which does the strobe timing. The request carries the flat target address and the row/column mask for the width under test.

The probe begins with the widest candidate and steps the candidate down by one on each failure. For each candidate it tests only the highest location that the candidate can reach. At that location it writes eight fixed byte patterns, reading each one back straight after writing it. When the probe stops, it reports four things:
- the width it settled on;
- a failure flag, if no candidate passed;
- the capacity in kilobytes, which depends on the width and on whether one or two row-strobe banks are fitted;
- the last pattern that mismatched, together with the byte that came back in its place.

Top module: `dram_geom_probe`

## Requirements
- R1: Reset (synchronous, active low) or a start pulse while `done` is high sets the candidate width to 12 and clears `detect_fail`, `diag_expect` and `diag_actual`. A new probe then begins. During reset, `req_valid` is 0, `done` is 0 and `busy` is 1. A start pulse while `busy` is high is ignored.
- R2: Every request for candidate width n carries `req_amask` = 2^n−1 and `req_addr` = 2^(2n)−1.
- R3: Within one candidate, the write data runs through 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03 in that order (write `req_write`=1, read `req_write`=0). Each write is followed by a read of the same address, and that read is issued only after the write has been accepted.
- R4: A read-back that differs from the pattern just written ends the current candidate at once. No further pattern is tried for it. The probe latches the pattern in `diag_expect` and the returned byte in `diag_actual`, and the candidate width falls by one.
- R5: A candidate whose eight read-backs all match ends the probe. Its width stays on `width` with `detect_fail`=0.
- R6: If candidate 9 fails, the probe ends with `width`=8 and `detect_fail`=1. The candidates tried are 12, 11, 10 and 9.
- R7: `size_kb` = 2^(2·width) × 4 × banks, where banks is 2 when `dual_bank`=1 and 1 otherwise.
- R8: Once the probe ends, `done` stays high and no request is issued until a start pulse arrives.
- R9: A request that is not yet accepted (`req_valid`=1, `req_ready`=0) stays valid with unchanged address, direction and data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart pulse, taken only while `done` is high |
| dual_bank | input | 1 | 1 = two row-strobe banks, 0 = one |
| req_valid | output | 1 | Request to the access controller |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 24 | Flat target address 2^(2n)−1 |
| req_amask | output | 12 | Row/column mask 2^n−1 |
| req_wdata | output | 8 | Pattern byte for writes |
| req_ready | input | 1 | Controller accepts the request this cycle |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 8 | Returned byte |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished |
| detect_fail | output | 1 | No candidate passed |
| width | output | 4 | Current or final candidate width |
| size_kb | output | 32 | Derived capacity in kilobytes |
| diag_expect | output | 8 | Last mismatching pattern |
| diag_actual | output | 8 | Byte read back for that pattern |

## Verification
The controller model in the bench corrupts exactly one chosen pattern, and only for candidates wider than a chosen true width. The vectors cover several cases:
- true widths of 12, 11, 10 and 9 show that the search stops at the correct candidate;
- a true width of 8 shows the failure path;
- placing the faulty pattern first, second, third or last shows that an abort happens at the correct point, which the write counts confirm.

Alternating single and dual banks separates the bank factor from the width term in the size. Runs with controller back-pressure and response delay show that requests are held and that reads are not issued early. A start pulse in the middle of a run shows that the pulse is ignored.

// File: rtl/dgp_pkg.sv
// Shared types and constants of the DRAM geometry probe.
// Assumes 8-bit data and an eight-entry test sequence.
package dgp_pkg;

    typedef enum logic [2:0] {
        PH_LAUNCH,
        PH_WRITE,
        PH_READ,
        PH_WAIT,
        PH_DONE
    } phase_t;

    localparam int PAT_COUNT = 8;

    // Test byte for a given step of the fixed sequence.
    function automatic logic [7:0] probe_pattern(input logic [2:0] step);
        case (step)
            3'd0:    return 8'hF0;
            3'd1:    return 8'h0F;
            3'd2:    return 8'hAA;
            3'd3:    return 8'h55;
            3'd4:    return 8'hC0;
            3'd5:    return 8'h30;
            3'd6:    return 8'h0C;
            default: return 8'h03;
        endcase
    endfunction

endpackage

// File: rtl/dgp_addr_gen.sv
// Address generator: turns a candidate width n into the row/column mask
// 2^n-1 and the flat top address 2^(2n)-1.
// Assumes width never exceeds MAX_W.
module dgp_addr_gen #(
    parameter int MAX_W = 12,
    parameter int WW    = 4
) (
    input  logic [WW-1:0]      width,
    output logic [MAX_W-1:0]   amask,
    output logic [2*MAX_W-1:0] addr
);
    localparam int AW = 2 * MAX_W;

    // Extended width for the doubled comparison.
    logic [WW:0] twice_w;
    assign twice_w = {width, 1'b0};

    // One mask bit per address line: set below the candidate width.
    for (genvar i = 0; i < MAX_W; i++) begin : g_mask
        assign amask[i] = (WW'(i) < width);
    end

    // One address bit per flat line: set below twice the width.
    for (genvar j = 0; j < AW; j++) begin : g_addr
        assign addr[j] = ((WW+1)'(j) < twice_w);
    end
endmodule

// File: rtl/dgp_size_calc.sv
// Capacity calculator: size in kilobytes = 2^(2n) * 4 * banks.
// Assumes 2*MAX_W+3 fits in SIZE_W bits.
module dgp_size_calc #(
    parameter int WW     = 4,
    parameter int SIZE_W = 32
) (
    input  logic [WW-1:0]     width,
    input  logic              dual_bank,
    output logic [SIZE_W-1:0] size_kb
);
    localparam int SH_W = WW + 2;

    logic [SH_W-1:0] shift;

    // Exponent: two per address bit, two for the byte factor, one per extra bank.
    always_comb begin
        shift   = SH_W'({width, 1'b0}) + SH_W'(2) + SH_W'(dual_bank);
        size_kb = SIZE_W'(1) << shift;
    end
endmodule

// File: rtl/dgp_seq.sv
// Probe sequencer: walks the candidate widths downward and steps through the
// write/read-back sequence. It latches diagnostics on a mismatch and stops at
// the first passing candidate, or after the lowest candidate above MIN_W.
// Assumes the controller returns exactly one response per accepted read.
module dgp_seq
    import dgp_pkg::*;
#(
    parameter int MAX_W = 12,
    parameter int MIN_W = 8,
    parameter int WW    = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    input  logic [7:0]       pat,
    output phase_t           phase,
    output logic [IDX_W-1:0] step,
    output logic [WW-1:0]    width,
    output logic             fail,
    output logic [7:0]       diag_exp,
    output logic [7:0]       diag_act
);
    localparam logic [WW-1:0]    W_TOP    = WW'(MAX_W);
    localparam logic [WW-1:0]    W_FLOOR  = WW'(MIN_W);
    localparam logic [IDX_W-1:0] STEP_END = IDX_W'(PAT_COUNT - 1);

    logic [WW-1:0] width_dn;
    assign width_dn = width - WW'(1);

    // Phase, candidate, step and diagnostic registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_LAUNCH;
            step     <= '0;
            width    <= W_TOP;
            fail     <= 1'b0;
            diag_exp <= '0;
            diag_act <= '0;
        end else begin
            case (phase)
                PH_LAUNCH: phase <= PH_WRITE;
                PH_WRITE:  if (req_ready) phase <= PH_READ;
                PH_READ:   if (req_ready) phase <= PH_WAIT;
                PH_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_data == pat) begin
                            if (step == STEP_END) begin
                                phase <= PH_DONE;
                            end else begin
                                step  <= step + IDX_W'(1);
                                phase <= PH_WRITE;
                            end
                        end else begin
                            diag_exp <= pat;
                            diag_act <= rsp_data;
                            step     <= '0;
                            width    <= width_dn;
                            if (width_dn > W_FLOOR) begin
                                phase <= PH_WRITE;
                            end else begin
                                fail  <= 1'b1;
                                phase <= PH_DONE;
                            end
                        end
                    end
                end
                PH_DONE: begin
                    if (start) begin
                        width    <= W_TOP;
                        step     <= '0;
                        fail     <= 1'b0;
                        diag_exp <= '0;
                        diag_act <= '0;
                        phase    <= PH_LAUNCH;
                    end
                end
                default: phase <= PH_LAUNCH;
            endcase
        end
    end
endmodule

// File: rtl/dram_geom_probe.sv
// DRAM geometry probe top level. It joins the sequencer, the pattern
// source, the address generator and the size calculator. Requests go to an
// external access controller through a valid/ready port; read data returns on
// rsp_valid/rsp_data. Assumes an 8-bit data path.
module dram_geom_probe
    import dgp_pkg::*;
#(
    parameter int MAX_W  = 12,
    parameter int MIN_W  = 8,
    parameter int SIZE_W = 32,
    localparam int WW    = $clog2(MAX_W + 1),
    localparam int AW    = 2 * MAX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dual_bank,
    output logic              req_valid,
    output logic              req_write,
    output logic [AW-1:0]     req_addr,
    output logic [MAX_W-1:0]  req_amask,
    output logic [7:0]        req_wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              busy,
    output logic              done,
    output logic              detect_fail,
    output logic [WW-1:0]     width,
    output logic [SIZE_W-1:0] size_kb,
    output logic [7:0]        diag_expect,
    output logic [7:0]        diag_actual
);
    localparam int IDX_W = $clog2(PAT_COUNT);

    phase_t           phase;
    logic [IDX_W-1:0] step;
    logic [7:0]       pat;

    // Current pattern byte for the sequencer's step.
    assign pat = probe_pattern(step);

    dgp_seq #(
        .MAX_W(MAX_W), .MIN_W(MIN_W), .WW(WW), .IDX_W(IDX_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pat(pat), .phase(phase), .step(step), .width(width),
        .fail(detect_fail), .diag_exp(diag_expect), .diag_act(diag_actual)
    );

    dgp_addr_gen #(.MAX_W(MAX_W), .WW(WW)) i_addr (
        .width(width), .amask(req_amask), .addr(req_addr)
    );

    dgp_size_calc #(.WW(WW), .SIZE_W(SIZE_W)) i_size (
        .width(width), .dual_bank(dual_bank), .size_kb(size_kb)
    );

    // Request and status decode from the phase.
    always_comb begin
        req_valid = (phase == PH_WRITE) || (phase == PH_READ);
        req_write = (phase == PH_WRITE);
        req_wdata = pat;
        done      = (phase == PH_DONE);
        busy      = !done;
    end
endmodule

// File: rtl/dram_geom_probe_chk.sv
// Checker for the DRAM geometry probe, attached through bind.
// Watches only the top-level ports.
module dram_geom_probe_chk #(
    parameter int MAX_W = 12,
    parameter int MIN_W = 8,
    parameter int WW    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               req_valid,
    input logic               req_write,
    input logic [2*MAX_W-1:0] req_addr,
    input logic [MAX_W-1:0]   req_amask,
    input logic [7:0]         req_wdata,
    input logic               req_ready,
    input logic               done,
    input logic               detect_fail,
    input logic [WW-1:0]      width
);
    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (width <= WW'(MAX_W)) && (width >= WW'(MIN_W))); // R1

    AST_ADDR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_addr) == 2 * $countones(req_amask))); // R2

    AST_WIDTH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (width <= $past(width))); // R4

    AST_FAIL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        detect_fail |-> (done && width == WW'(MIN_W))); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write)
            && $stable(req_wdata) && $stable(req_addr))); // R9
endmodule

bind dram_geom_probe dram_geom_probe_chk #(
    .MAX_W(MAX_W), .MIN_W(MIN_W), .WW(WW)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_amask(req_amask),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .detect_fail(detect_fail), .width(width)
);

// File: tb/test_dram_geom_probe.sv
`timescale 1ns/1ps
module test_dram_geom_probe;
    localparam int MAX_W = 12;
    localparam int AW    = 24;

    typedef struct packed {
        logic [3:0]  true_w;
        logic        dual;
        logic [7:0]  bad;
        logic        stall;
        logic [3:0]  exp_w;
        logic        exp_fail;
        logic [31:0] exp_size;
        logic [7:0]  exp_de;
        logic [7:0]  exp_da;
        logic [7:0]  exp_writes;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{4'd12, 1'b0, 8'hF0, 1'b0, 4'd12, 1'b0, 32'd67108864, 8'h00, 8'h00, 8'd8},
        '{4'd11, 1'b1, 8'h0F, 1'b1, 4'd11, 1'b0, 32'd33554432, 8'h0F, 8'h0E, 8'd10},
        '{4'd9,  1'b0, 8'hF0, 1'b0, 4'd9,  1'b0, 32'd1048576,  8'hF0, 8'hF1, 8'd11},
        '{4'd8,  1'b0, 8'h03, 1'b1, 4'd8,  1'b1, 32'd262144,   8'h03, 8'h02, 8'd32},
        '{4'd10, 1'b1, 8'hAA, 1'b0, 4'd10, 1'b0, 32'd8388608,  8'hAA, 8'hAB, 8'd14}
    };
    localparam logic [7:0] PATS [8] = '{8'hF0, 8'h0F, 8'hAA, 8'h55,
                                        8'hC0, 8'h30, 8'h0C, 8'h03};

    logic clk = 1'b0;
    logic rst_n = 1'b0, start = 1'b0, dual_bank = 1'b0;
    logic req_valid, req_write, busy, done, detect_fail;
    logic [AW-1:0] req_addr;
    logic [MAX_W-1:0] req_amask;
    logic [7:0] req_wdata, rsp_data_o, diag_expect, diag_actual;
    logic req_ready = 1'b1, rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic [3:0] width;
    logic [31:0] size_kb;

    int total = 0, bad = 0;
    int m_true_w = 12, m_stall = 0, m_writes = 0, m_pidx = 0, m_cur_n = 0;
    int m_pend = 0, m_rd_n = 0, m_cyc = 0;
    logic [7:0] m_bad = 8'hF0, m_mem = 8'h00;
    logic m_last_wr = 1'b0, m_hold = 1'b0, m_hw = 1'b0;
    logic [7:0] m_hd = 8'h00;
    logic [AW-1:0] m_ha = '0, m_waddr = '0;

    assign rsp_data_o = rsp_data;

    always #2.5 clk = ~clk;

    dram_geom_probe i_dram_geom_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .dual_bank(dual_bank),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_amask(req_amask), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data_o), .busy(busy), .done(done),
        .detect_fail(detect_fail), .width(width), .size_kb(size_kb),
        .diag_expect(diag_expect), .diag_actual(diag_actual)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Access controller model: it corrupts bit 0 of the chosen pattern on
    // candidates wider than the true width, and optionally stalls.
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (m_pend == 1) begin
                rsp_valid = 1'b1;
                rsp_data  = (m_rd_n > m_true_w && m_mem == m_bad) ? (m_mem ^ 8'h01) : m_mem;
            end
            if (m_pend > 0) m_pend--;
            req_ready = (m_stall != 0) ? ((m_cyc % 3) != 2) : 1'b1;
            m_cyc++;
            if (m_hold) begin
                check(req_valid && req_write == m_hw && req_wdata == m_hd && req_addr == m_ha,
                      "R9 held request", longint'(req_wdata), longint'(m_hd));
                m_hold = 1'b0;
            end
            if (rst_n && done && req_valid)
                check(1'b0, "R8 request after done", 1, 0);
            if (rst_n && req_valid) begin
                if (!req_ready) begin
                    m_hold = 1'b1; m_hw = req_write; m_hd = req_wdata; m_ha = req_addr;
                end else if (req_write) begin
                    automatic int n = $countones(req_amask);
                    if (n != m_cur_n) begin m_cur_n = n; m_pidx = 0; end
                    check(req_amask == MAX_W'((1 << n) - 1) && req_addr == AW'((1 << (2*n)) - 1),
                          "R2 address for candidate", longint'(req_addr), (longint'(1) << (2*n)) - 1);
                    check(m_pidx < 8 && req_wdata == PATS[m_pidx & 7], "R3 pattern order",
                          longint'(req_wdata), longint'(PATS[m_pidx & 7]));
                    m_pidx++;
                    m_mem = req_wdata; m_waddr = req_addr; m_last_wr = 1'b1; m_writes++;
                end else begin
                    check(m_last_wr && req_addr == m_waddr, "R3 read follows accepted write",
                          longint'(m_last_wr), 1);
                    m_last_wr = 1'b0;
                    m_rd_n = $countones(req_amask);
                    m_pend = (m_stall != 0) ? 3 : 1;
                end
            end
        end
    end

    task automatic load_cfg(input int i);
        m_true_w = int'(VECS[i].true_w);
        m_bad = VECS[i].bad;
        m_stall = int'(VECS[i].stall);
        dual_bank = VECS[i].dual;
        m_writes = 0; m_pidx = 0; m_cur_n = 0;
    endtask

    task automatic run_vec(input int i, input bit use_start, input bit mid_start);
        if (use_start) begin
            @(negedge clk);
            load_cfg(i);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (mid_start) begin
                repeat (6) @(negedge clk);
                start = 1'b1;  // R1: ignored while busy
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (!done) @(negedge clk);
        check(width == VECS[i].exp_w, $sformatf("R5/R6 width v%0d", i), width, VECS[i].exp_w);
        check(detect_fail == VECS[i].exp_fail, $sformatf("R6 fail flag v%0d", i),
              detect_fail, VECS[i].exp_fail);
        check(size_kb == VECS[i].exp_size, $sformatf("R7 size v%0d", i), size_kb, VECS[i].exp_size);
        check(diag_expect == VECS[i].exp_de && diag_actual == VECS[i].exp_da,
              $sformatf("R4 diagnostics v%0d", i),
              longint'({diag_expect, diag_actual}), longint'({VECS[i].exp_de, VECS[i].exp_da}));
        check(m_writes == int'(VECS[i].exp_writes), $sformatf("R4 abort write count v%0d", i),
              m_writes, VECS[i].exp_writes);
        repeat (20) @(negedge clk);
        check(done && !req_valid && busy == 1'b0, $sformatf("R8 idle after done v%0d", i),
              done, 1);
    endtask

    initial begin
        load_cfg(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!req_valid && !done && busy && width == 4'd12 && !detect_fail,
              "R1 reset state", width, 12);
        rst_n = 1'b1;
        run_vec(0, 1'b0, 1'b0);
        for (int v = 1; v < NV; v++) run_vec(v, 1'b1, v == NV - 1);
        @(negedge clk);
        load_cfg(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !detect_fail && diag_expect == 8'h00 && width == 4'd12,
              "R1 restart clears state", width, 12);
        while (!done) @(negedge clk);
        check(width == 4'd12 && size_kb == 32'd67108864, "R7 restart result", size_kb, 67108864);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule